// File: doc/BRIEF.md
# MDIO Management Command Decoder

This block turns register writes from software into Clause 22 management frames on an MDC/MDIO pair. Software loads a control word, and for some commands a data word. The decoder extracts the PHY address, the register address, the operation and the write data. A frame engine then serialises the transaction, and a programmable divider generates the management clock.

Two control-word layouts coexist. A single feature bit chooses which one decodes writes to the control register. In the older layout, separate read and write request bits start a transaction. Write data comes from the low half of the data register, and read data lands in its high half. In the newer layout, a start bit starts the transaction. A Clause 22 marker and a 2-bit opcode must be valid, write data travels in the control word itself, and read data lands in the low half of the data register. In both layouts the bit that started the transaction clears itself at completion. A busy output covers the whole transaction.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: With the feature bit clear (older layout), control bit 27 requests a write and bit 26 requests a read. Bits 20:16 hold the PHY address and bits 25:21 the register address. Write data is bits 15:0 of the data register. When both request bits are set, the write is performed.
- R2: In the older layout, a completed read puts the 16 received bits into data register bits 31:16 and clears bits 15:0.
- R3: In the older layout, completion clears only the request bit that was executed. A control write with neither request bit set stores the word and starts nothing.
- R4: With the feature bit set (newer layout), bit 15 starts a command, bit 12 marks Clause 22, and bits 11:10 give the opcode (01 write, 10 read). Bits 9:5 hold the PHY address, bits 4:0 the register address and bits 31:16 the write data. Bit 15 clears at completion.
- R5: In the newer layout, a completed read puts the received bits into data register bits 15:0 and clears bits 31:16.
- R6: In the newer layout, a start with bit 12 clear starts nothing and the word is stored unchanged. A start with opcode 00 or 11 starts nothing and is stored with bit 15 cleared. A word with bit 15 clear starts nothing.
- R7: Feature register bit 31 selects the newer layout. Reset selects the older layout.
- R8: Each frame is 64 bits, sent MSB first: 32 ones, start 01, opcode, 5-bit PHY address, 5-bit register address, turnaround, 16 data bits. A write turnaround is 10. On a read, MDIO is released (mdio_oe low) from the turnaround onward.
- R9: MDC is low while idle. Each bit lasts 2*CLK_DIV clock cycles, with MDC high for the second half. MDIO changes only when MDC falls. Read data is sampled on the clock edge where MDC rises.
- R10: busy rises on the edge that accepts a starting control write and stays high for exactly 128*CLK_DIV cycles. The starting bit stays set until busy falls and clears on that same edge.
- R11: While busy is high, writes to the control, data and feature registers are ignored.
- R12: Synchronous active-low reset clears the control and data registers and the feature bit, aborts any frame, and leaves busy, mdc and mdio_oe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 data, 2 feature |
| wr_data | input | 32 | Write data |
| ctrl_q | output | 32 | Current control register |
| data_q | output | 32 | Current data register |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Register writes and the decision to start are visible one edge after the write strobe is taken. The bench samples on the falling clock edge that follows that edge. From the write edge, busy lasts 128*CLK_DIV cycles, so the bench counts falling edges while busy is high. It compares the total against that figure and only then reads the cleared command bit and the captured read data. A PHY model in the bench records MDIO on every rising MDC edge and presents read bits on each falling MDC edge, so reply bits are already stable when the design samples them.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the MDIO command decoder.
// Assumes Clause 22 framing only; the frame length follows from the preamble.
package mdio_pkg;
    localparam int PREAMBLE_BITS = 32;
    localparam int FRAME_BITS    = PREAMBLE_BITS + 32;
    localparam int TA_POS        = PREAMBLE_BITS + 14;
    localparam int DATA_POS      = PREAMBLE_BITS + 16;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_FEAT = 2'd2;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    localparam int OLD_RD_BIT   = 26;
    localparam int OLD_WR_BIT   = 27;
    localparam int NEW_GO_BIT   = 15;
    localparam int NEW_C22_BIT  = 12;
    localparam int FEAT_NEW_BIT = 31;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: while run is high, produces a clock with a period of
// 2*CLK_DIV core cycles, low first. Strobes mark the edges where MDC rises/falls.
// Assumes CLK_DIV >= 1; MDC is held low while run is low.
module mdio_clkgen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(2 * CLK_DIV);
    localparam logic [CW-1:0] RISE_AT = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] FALL_AT = CW'(2 * CLK_DIV - 1);

    logic [CW-1:0] cnt;

    // Edge strobes derived from the phase counter.
    always_comb begin
        rise = run && (cnt == RISE_AT);
        fall = run && (cnt == FALL_AT);
    end

    // Phase counter and MDC register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= fall ? '0 : cnt + 1'b1;
            if (rise) mdc <= 1'b1;
            if (fall) mdc <= 1'b0;
        end
    end

    p_mdc_low_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: on go, loads a full Clause 22 frame and shifts it out MSB
// first, one bit per MDC period. On reads it releases MDIO from the turnaround
// and collects 16 data bits on MDC rising edges. done pulses on the edge that
// ends the last bit.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  mdio_cmd_t   cmd,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_word
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] TA_BIT   = BW'(TA_POS);
    localparam logic [BW-1:0] DATA_BIT = BW'(DATA_POS);

    logic [FRAME_BITS-1:0] shreg;
    logic [BW-1:0]         bitcnt;
    logic                  is_read;
    logic [17:0]           tail;

    // Turnaround and data field: driven on writes, placeholder ones on reads.
    always_comb begin
        tail = (cmd.op == OP_RD) ? 18'h3FFFF : {2'b10, cmd.wdata};
    end

    // Frame shift register, bit counter and activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bitcnt  <= '0;
            shreg   <= '0;
            is_read <= 1'b0;
        end else if (go) begin
            active  <= 1'b1;
            bitcnt  <= '0;
            is_read <= (cmd.op == OP_RD);
            shreg   <= {{PREAMBLE_BITS{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regad, tail};
        end else if (active && fall) begin
            shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) active <= 1'b0;
        end
    end

    // Read data capture on MDC rising edges during the data field.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            rd_word <= '0;
        end else if (active && rise && is_read && bitcnt >= DATA_BIT) begin
            rd_word <= {rd_word[14:0], mdio_i};
        end
    end

    // Pin drive and completion strobe.
    always_comb begin
        mdio_o  = shreg[FRAME_BITS-1];
        mdio_oe = active && !(is_read && bitcnt >= TA_BIT);
        done    = active && fall && (bitcnt == LAST_BIT);
    end

    p_mdio_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fall) |=> $stable(mdio_o));
    p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_read && fall && bitcnt == TA_BIT - 1'b1) |=> !mdio_oe);
    p_write_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !is_read) |-> mdio_oe);
endmodule

// File: rtl/mdio_cmd_decode.sv
// Register bank and command decoder. Holds the control, data and feature
// registers, decodes control writes in the layout chosen by the feature bit,
// issues go to the frame engine, and on done clears the start bit and places
// read data. All writes are ignored while a transaction is in progress.
module mdio_cmd_decode
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        busy,
    input  logic        done,
    input  logic [15:0] rd_word,
    output logic [31:0] ctrl_q,
    output logic [31:0] data_q,
    output logic        go,
    output mdio_cmd_t   cmd
);
    logic       new_mode_q;
    logic       cmd_new_q;
    logic       cmd_read_q;
    logic       accept;
    logic       ctrl_wr;
    logic       new_go;
    logic       new_c22;
    logic [1:0] new_op;
    logic       new_ok;
    logic       old_any;

    // Field extraction and start decision for both layouts.
    always_comb begin
        accept  = wr_en && !busy;
        ctrl_wr = accept && (wr_sel == SEL_CTRL);
        new_go  = wr_data[NEW_GO_BIT];
        new_c22 = wr_data[NEW_C22_BIT];
        new_op  = wr_data[11:10];
        new_ok  = new_go && new_c22 && (new_op == OP_WR || new_op == OP_RD);
        old_any = wr_data[OLD_WR_BIT] || wr_data[OLD_RD_BIT];
        if (new_mode_q) begin
            cmd.op    = new_op;
            cmd.phy   = wr_data[9:5];
            cmd.regad = wr_data[4:0];
            cmd.wdata = wr_data[31:16];
            go        = ctrl_wr && new_ok;
        end else begin
            cmd.op    = wr_data[OLD_WR_BIT] ? OP_WR : OP_RD;
            cmd.phy   = wr_data[20:16];
            cmd.regad = wr_data[25:21];
            cmd.wdata = data_q[15:0];
            go        = ctrl_wr && old_any;
        end
    end

    // Layout select register.
    always_ff @(posedge clk) begin
        if (!rst_n) new_mode_q <= 1'b0;
        else if (accept && wr_sel == SEL_FEAT) new_mode_q <= wr_data[FEAT_NEW_BIT];
    end

    // Remember the layout and direction of the running command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_new_q  <= 1'b0;
            cmd_read_q <= 1'b0;
        end else if (go) begin
            cmd_new_q  <= new_mode_q;
            cmd_read_q <= (cmd.op == OP_RD);
        end
    end

    // Control register: store writes, drop invalid new-layout starts, self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data;
            if (new_mode_q && new_go && new_c22 && !new_ok) ctrl_q[NEW_GO_BIT] <= 1'b0;
        end else if (done) begin
            if (cmd_new_q)       ctrl_q[NEW_GO_BIT] <= 1'b0;
            else if (cmd_read_q) ctrl_q[OLD_RD_BIT] <= 1'b0;
            else                 ctrl_q[OLD_WR_BIT] <= 1'b0;
        end
    end

    // Data register: software writes low half; reads placed per layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept && wr_sel == SEL_DATA) begin
            data_q <= {16'h0, wr_data[15:0]};
        end else if (done && cmd_read_q) begin
            data_q <= cmd_new_q ? {16'h0, rd_word} : {rd_word, 16'h0};
        end
    end

    p_ctrl_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_en && wr_sel == SEL_CTRL) |=> ctrl_q == $past(ctrl_q));
    p_data_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_en && wr_sel == SEL_DATA) |=> data_q == $past(data_q));
    p_old_wr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd_new_q && !cmd_read_q) |=> !ctrl_q[OLD_WR_BIT]);
    p_new_go_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_new_q) |=> !ctrl_q[NEW_GO_BIT]);
    p_old_rd_place_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd_new_q && cmd_read_q) |=> data_q[15:0] == 16'h0);
    p_new_rd_place_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_new_q && cmd_read_q) |=> data_q[31:16] == 16'h0);
endmodule

// File: rtl/mdio_cmd_ctrl.sv
// Top of the MDIO command decoder: register decode, frame engine and MDC
// divider. CLK_DIV sets the MDC half-period in core clock cycles.
// Assumes one outstanding transaction; writes during busy are dropped.
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_q,
    output logic [31:0] data_q,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        go;
    logic        done;
    logic        rise;
    logic        fall;
    logic [15:0] rd_word;
    mdio_cmd_t   cmd;

    mdio_cmd_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .busy    (busy),
        .done    (done),
        .rd_word (rd_word),
        .ctrl_q  (ctrl_q),
        .data_q  (data_q),
        .go      (go),
        .cmd     (cmd)
    );

    mdio_frame_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .cmd     (cmd),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .active  (busy),
        .done    (done),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_word (rd_word)
    );

    mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    p_mdc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    p_oe_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
endmodule

// File: tb/test_mdio_cmd_ctrl.sv
// Self-checking bench: vector table of commands, then directed tests.
module test_mdio_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int XFER       = 128 * DIV;

    typedef struct packed {
        logic        newm;
        logic [15:0] dreg;
        logic [31:0] ctrl;
        logic [15:0] reply;
        logic        started;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wd;
        logic [31:0] exp_data;
        logic [31:0] exp_ctrl;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b0, 16'hA5C3, 32'h0923_0000, 16'h0000, 1'b1, 2'b01, 5'd3,  5'd9,  16'hA5C3, 32'h0000_A5C3, 32'h0123_0000},
        '{1'b0, 16'h1234, 32'h0441_0000, 16'hBEEF, 1'b1, 2'b10, 5'd1,  5'd2,  16'h0000, 32'hBEEF_0000, 32'h0041_0000},
        '{1'b0, 16'h0F0F, 32'h0FFF_0000, 16'h0000, 1'b1, 2'b01, 5'd31, 5'd31, 16'h0F0F, 32'h0000_0F0F, 32'h07FF_0000},
        '{1'b0, 16'h5555, 32'h03FF_1234, 16'h0000, 1'b0, 2'b00, 5'd0,  5'd0,  16'h0000, 32'h0000_5555, 32'h03FF_1234},
        '{1'b1, 16'h0000, 32'hC0DE_94E4, 16'h0000, 1'b1, 2'b01, 5'd7,  5'd4,  16'hC0DE, 32'h0000_0000, 32'hC0DE_14E4},
        '{1'b1, 16'h1111, 32'hFFFF_9AAA, 16'h6789, 1'b1, 2'b10, 5'h15, 5'h0A, 16'h0000, 32'h0000_6789, 32'hFFFF_1AAA},
        '{1'b1, 16'h2222, 32'h0000_8421, 16'h0000, 1'b0, 2'b00, 5'd0,  5'd0,  16'h0000, 32'h0000_2222, 32'h0000_8421},
        '{1'b1, 16'h3333, 32'h0000_9021, 16'h0000, 1'b0, 2'b00, 5'd0,  5'd0,  16'h0000, 32'h0000_3333, 32'h0000_1021},
        '{1'b1, 16'h4444, 32'h0000_9C21, 16'h0000, 1'b0, 2'b00, 5'd0,  5'd0,  16'h0000, 32'h0000_4444, 32'h0000_1C21},
        '{1'b1, 16'h6666, 32'h0000_1421, 16'h0000, 1'b0, 2'b00, 5'd0,  5'd0,  16'h0000, 32'h0000_6666, 32'h0000_1421},
        '{1'b1, 16'h7777, 32'h0923_0000, 16'h0000, 1'b0, 2'b00, 5'd0,  5'd0,  16'h0000, 32'h0000_7777, 32'h0923_0000},
        '{1'b0, 16'h8888, 32'hC0DE_94E4, 16'h0000, 1'b0, 2'b00, 5'd0,  5'd0,  16'h0000, 32'h0000_8888, 32'hC0DE_94E4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_q;
    logic [31:0] data_q;
    logic        busy;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int          tests = 0;
    int          fails = 0;
    bit          finished = 1'b0;
    int          rcount = 0;
    logic [63:0] cap = '0;
    logic [15:0] reply = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_cmd_ctrl #(.CLK_DIV(DIV)) i_mdio_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .data_q(data_q), .busy(busy), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: record each bit on MDC rise, present read bits on MDC fall.
    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_o};
        rcount = rcount + 1;
    end
    always @(negedge mdc) begin
        if (rcount >= 48 && rcount <= 63 && !mdio_oe) mdio_i = reply[63 - rcount];
        else mdio_i = 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic run_out(output int n, output int h);
        n = 0; h = 0;
        while (busy && n < 4 * XFER) begin
            n++;
            if (mdc) h++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int h;
        logic [63:0] fexp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 ctrl after reset", ctrl_q, 0);
        chk("R12 data after reset", data_q, 0);
        chk("R12 busy/mdc/oe after reset", {busy, mdc, mdio_oe}, 0);

        // Vector table: R1..R10
        for (int i = 0; i < 12; i++) begin
            wr(mdio_pkg::SEL_FEAT, {VECS[i].newm, 31'h0});
            wr(mdio_pkg::SEL_DATA, {16'h0, VECS[i].dreg});
            reply = VECS[i].reply; rcount = 0; cap = '0;
            wr(mdio_pkg::SEL_CTRL, VECS[i].ctrl);
            chk($sformatf("R10 v%0d busy after write", i), busy, VECS[i].started);
            if (VECS[i].started) begin
                chk($sformatf("R10 v%0d start bit held", i), ctrl_q, VECS[i].ctrl);
                run_out(n, h);
                chk($sformatf("R10 v%0d busy length", i), n, XFER);
                chk($sformatf("R9 v%0d mdc high cycles", i), h, 64 * DIV);
                chk($sformatf("R8 v%0d mdc rises", i), rcount, 64);
                fexp = {32'hFFFF_FFFF, 2'b01, VECS[i].op, VECS[i].phy, VECS[i].regad,
                        2'b10, VECS[i].wd};
                if (VECS[i].op == 2'b10)
                    chk($sformatf("R8 R1 R4 v%0d read frame head", i), cap[63:18], fexp[63:18]);
                else
                    chk($sformatf("R8 R1 R4 v%0d write frame", i), cap, fexp);
            end else begin
                repeat (4) @(negedge clk);
                chk($sformatf("R3 R6 R7 v%0d nothing started", i), {busy, rcount[7:0]}, 0);
            end
            chk($sformatf("R3 R4 R6 v%0d ctrl after", i), ctrl_q, VECS[i].exp_ctrl);
            chk($sformatf("R2 R5 v%0d data after", i), data_q, VECS[i].exp_data);
        end

        // R11: writes during busy are ignored
        wr(mdio_pkg::SEL_FEAT, 32'h0);
        wr(mdio_pkg::SEL_DATA, 32'h0000_00AA);
        rcount = 0; cap = '0;
        wr(mdio_pkg::SEL_CTRL, 32'h0923_0000);
        repeat (10) @(negedge clk);
        wr(mdio_pkg::SEL_CTRL, 32'hFFFF_FFFF);
        wr(mdio_pkg::SEL_DATA, 32'h0000_FFFF);
        wr(mdio_pkg::SEL_FEAT, 32'h8000_0000);
        run_out(n, h);
        chk("R11 ctrl unaffected by busy write", ctrl_q, 32'h0123_0000);
        chk("R11 data unaffected by busy write", data_q, 32'h0000_00AA);
        chk("R11 frame data unaffected", cap[15:0], 16'h00AA);
        reply = 16'h0001; rcount = 0;
        wr(mdio_pkg::SEL_CTRL, 32'h0441_0000);
        chk("R11 feature write ignored (older layout still active)", busy, 1'b1);
        run_out(n, h);
        chk("R2 single-bit read reply", data_q, 32'h0001_0000);

        // R12: reset mid-frame, then R7 default older layout
        wr(mdio_pkg::SEL_FEAT, 32'h8000_0000);
        wr(mdio_pkg::SEL_CTRL, 32'hC0DE_94E4);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R12 ctrl after mid-frame reset", ctrl_q, 0);
        chk("R12 busy/mdc/oe after mid-frame reset", {busy, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        wr(mdio_pkg::SEL_CTRL, 32'h0923_0000);
        chk("R7 reset selects older layout", busy, 1'b1);
        run_out(n, h);
        chk("R7 older layout write completes", ctrl_q, 32'h0123_0000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule